// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port

This block is a general-purpose parallel port that a processor reaches through a small synchronous register slave with a two-bit word address. Elaboration parameters set the port width (1 to 32 bits) and the pin arrangement. The pins can be a bidirectional group with a per-bit drive enable, an input-only group, separate input and output groups, or an output-only group. Pad-level tri-state cells stay outside the block, so a bidirectional pin appears as three signals: the pad value coming in, the value to drive, and a drive enable.

Inputs pass through a two-flop synchronizer. Optional capture logic latches qualifying edges of the synchronized inputs into sticky bits. The qualifying edge is chosen by a parameter: rising, falling, either, or off. A single interrupt line can follow either of two sources. In level mode it follows the masked synchronized inputs. In edge mode it follows the masked capture bits, and edge mode is rejected at elaboration unless capture is on. The output-only arrangement never interrupts.

The slave has no valid/ready back-pressure. A write completes in the cycle of its strobe. A read presents its word exactly one cycle after the strobe, so the master does not need to wait on a handshake.

Top module: `pio_port`

## Requirements
- R1: After reset, `pin_out`, the direction register, the mask register and the capture bits are all zero. In bidirectional mode this means `pin_oe` is zero and every pin starts as an input. `irq` and `rdata` are low.
- R2: A read strobe sampled at one rising edge puts the addressed word on `rdata` for the next cycle. In every cycle that does not follow a read strobe, `rdata` is zero.
- R3: A write to offset 0 loads `wdata[WIDTH-1:0]` into the output register, and `pin_out` shows the new value from the next cycle on. This applies in every arrangement that has outputs.
- R4: Offset 1 holds the direction bits, where 1 means drive the pin, and in bidirectional mode `pin_oe` equals this register. In the separate-port and output-only arrangements `pin_oe` is all ones, and in input-only it is all zeros.
- R5: A read of offset 0 returns `pin_in` after two synchronizer flops. A value that has been on `pin_in` for two rising edges before the read strobe's edge is the value returned; a value present for only one edge is not yet visible.
- R6: With capture on, a capture bit is set when the current synchronized sample and the previous one differ in the selected direction: rising is 0 to 1, falling is 1 to 0, either is any change. Once set, a bit stays set until it is cleared. A read of offset 3 returns the capture bits.
- R7: A write of any value to offset 3 clears all capture bits, except that a bit whose edge is detected in the same cycle ends up set.
- R8: In edge interrupt mode, `irq` is high exactly when some capture bit and the matching bit of the mask register (offset 2) are both 1.
- R9: In level interrupt mode, `irq` is high exactly when some synchronized input bit and the matching mask bit are both 1.
- R10: Reads return zero in bit positions at and above `WIDTH`, and for any offset whose register the chosen arrangement lacks. In the output-only arrangement this covers every offset, and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word offset of the access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data, valid the cycle after `rd` |
| pin_in | input | WIDTH | Pad input values |
| pin_out | output | WIDTH | Values to drive on the pins |
| pin_oe | output | WIDTH | Per-pin drive enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets a clear write that lands in the same cycle as a fresh edge. A design that gave the clear priority would lose that edge, and the capture readback would come back zero instead of showing the new bit. It checks read latency against synchronizer depth by reading one cycle after an input change and again a cycle later. A design with one sync stage too few or too many returns the wrong word in one of those two reads. Three arrangements run side by side. Polarity mistakes show up as a falling edge caught, or missed, in the wrong instance. Mask mistakes leave `irq` high while the only active bits are masked. A design that decodes absent registers returns nonzero words from the input/output and output-only instances.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    PIO_BIDIR    = 2'd0,
    PIO_IN_ONLY  = 2'd1,
    PIO_IN_OUT   = 2'd2,
    PIO_OUT_ONLY = 2'd3
  } pio_mode_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'd0,
    IRQ_LEVEL = 2'd1,
    IRQ_EDGE  = 2'd2
  } irq_src_e;

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_DIR  = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;
  localparam logic [1:0] OFS_EDGE = 2'd3;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/pio_edge_cap.sv
module pio_edge_cap
  import pio_pkg::*;
#(
  parameter int        W   = 8,
  parameter edge_sel_e SEL = EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] prev,
  input  logic         clr,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] hit
);
  generate
    case (SEL)
      EDGE_RISE: begin : g_rise
        assign hit = sample & ~prev;
      end
      EDGE_FALL: begin : g_fall
        assign hit = ~sample & prev;
      end
      EDGE_BOTH: begin : g_both
        assign hit = sample ^ prev;
      end
      default: begin : g_off
        logic unused_cmp;
        assign unused_cmp = ^{sample, prev};
        assign hit = '0;
      end
    endcase
  endgenerate

  // a detected edge overrides a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= (clr ? '0 : cap_q) | hit;
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int        WIDTH       = 8,
  parameter int        BUS_W       = 32,
  parameter pio_mode_e MODE        = PIO_BIDIR,
  parameter edge_sel_e EDGE        = EDGE_RISE,
  parameter irq_src_e  IRQ         = IRQ_EDGE,
  parameter int        SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             irq
);
  localparam bit HAS_IN  = (MODE != PIO_OUT_ONLY);
  localparam bit HAS_OUT = (MODE != PIO_IN_ONLY);
  localparam bit IS_TRI  = (MODE == PIO_BIDIR);
  localparam bit CAP_ON  = HAS_IN && (EDGE != EDGE_OFF);
  localparam bit IRQ_ON  = HAS_IN && (IRQ != IRQ_OFF);

  generate
    if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("pio_port: WIDTH must be within 1..32");
    end
    if (BUS_W < WIDTH) begin : g_bad_bus
      $error("pio_port: BUS_W narrower than WIDTH");
    end
    if (IRQ == IRQ_EDGE && HAS_IN && !CAP_ON) begin : g_bad_irq
      $error("pio_port: edge interrupt needs edge capture");
    end
  endgenerate

  logic [WIDTH-1:0] wd;
  logic [WIDTH-1:0] sync_q, prev_q, cap_bits, edge_hit;
  logic [WIDTH-1:0] out_q, dir_q, mask_q;
  logic [BUS_W-1:0] rd_word, rdata_q;
  logic             wr_clr;
  logic             unused_bits;

  assign wd          = wdata[WIDTH-1:0];
  assign wr_clr      = wr && (addr == OFS_EDGE);
  assign unused_bits = ^{wdata, pin_in, prev_q, wr_clr};

  // input path
  generate
    if (HAS_IN) begin : g_in
      pio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .q      (sync_q),
        .q_prev (prev_q)
      );
      pio_edge_cap #(.W(WIDTH), .SEL(EDGE)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sync_q),
        .prev   (prev_q),
        .clr    (wr_clr),
        .cap_q  (cap_bits),
        .hit    (edge_hit)
      );
    end else begin : g_no_in
      assign sync_q   = '0;
      assign prev_q   = '0;
      assign cap_bits = '0;
      assign edge_hit = '0;
    end
  endgenerate

  // output data register
  generate
    if (HAS_OUT) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       out_q <= '0;
        else if (wr && addr == OFS_DATA)  out_q <= wd;
      end
    end else begin : g_no_out
      assign out_q = '0;
    end
  endgenerate

  // direction register (bidirectional only)
  generate
    if (IS_TRI) begin : g_dir
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      dir_q <= '0;
        else if (wr && addr == OFS_DIR)  dir_q <= wd;
      end
      assign pin_oe = dir_q;
    end else begin : g_no_dir
      assign dir_q  = '0;
      assign pin_oe = {WIDTH{HAS_OUT}};
    end
  endgenerate

  // interrupt mask and source
  generate
    if (IRQ_ON) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       mask_q <= '0;
        else if (wr && addr == OFS_MASK)  mask_q <= wd;
      end
    end else begin : g_no_mask
      assign mask_q = '0;
    end

    if (IRQ_ON && IRQ == IRQ_LEVEL) begin : g_irq_lvl
      assign irq = |(sync_q & mask_q);
    end else if (IRQ_ON && IRQ == IRQ_EDGE) begin : g_irq_edge
      assign irq = |(cap_bits & mask_q);
    end else begin : g_irq_none
      assign irq = 1'b0;
    end
  endgenerate

  // read mux and one-wait-state read register
  always_comb begin
    rd_word = '0;
    unique case (addr)
      OFS_DATA: rd_word[WIDTH-1:0] = sync_q;
      OFS_DIR:  rd_word[WIDTH-1:0] = dir_q;
      OFS_MASK: rd_word[WIDTH-1:0] = mask_q;
      default:  rd_word[WIDTH-1:0] = cap_bits;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd ? rd_word : '0;
  end

  assign rdata   = rdata_q;
  assign pin_out = out_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
  import pio_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter int        BUS_W = 32,
  parameter pio_mode_e MODE  = PIO_BIDIR
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             rd,
  input logic             wr,
  input logic [WIDTH-1:0] wdata_lo,
  input logic [BUS_W-1:0] rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic             irq,
  input logic [WIDTH-1:0] cap_bits,
  input logic [WIDTH-1:0] edge_hit
);
  localparam bit HAS_OUT = (MODE != PIO_IN_ONLY);
  localparam bit IS_TRI  = (MODE == PIO_BIDIR);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && !irq && cap_bits == '0
                      && (pin_oe & {WIDTH{IS_TRI}}) == '0));

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> rdata == '0);

  assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_OUT && wr && addr == OFS_DATA) |=> pin_out == $past(wdata_lo));

  assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_TRI && wr && addr == OFS_DIR) |=> pin_oe == $past(wdata_lo));

  assert_cap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_EDGE) |=> ($past(cap_bits) & ~cap_bits) == '0);

  assert_cap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_EDGE) |=> cap_bits == $past(edge_hit));

  generate
    if (WIDTH < BUS_W) begin : g_hi
      assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUS_W-1:WIDTH] == '0);
    end
  endgenerate
endmodule

bind pio_port pio_port_chk #(.WIDTH(WIDTH), .BUS_W(BUS_W), .MODE(MODE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .rd       (rd),
  .wr       (wr),
  .wdata_lo (wdata[WIDTH-1:0]),
  .rdata    (rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .irq      (irq),
  .cap_bits (cap_bits),
  .edge_hit (edge_hit)
);

// File: tb/tb_pio_port.sv
module tb_pio_port;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  pin_in = '0;

  logic [31:0] rdata_a, rdata_b, rdata_c;
  logic [7:0]  out_a, oe_a, out_b, oe_b;
  logic [3:0]  out_c, oe_c;
  logic        irq_a, irq_b, irq_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // bidirectional, rising capture, edge interrupt
  pio_port #(.WIDTH(8), .MODE(PIO_BIDIR), .EDGE(EDGE_RISE), .IRQ(IRQ_EDGE)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata_a), .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

  // separate in/out, either-edge capture, level interrupt
  pio_port #(.WIDTH(8), .MODE(PIO_IN_OUT), .EDGE(EDGE_BOTH), .IRQ(IRQ_LEVEL)) dut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata_b), .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

  // output only, 4 bits
  pio_port #(.WIDTH(4), .MODE(PIO_OUT_ONLY), .EDGE(EDGE_OFF), .IRQ(IRQ_OFF)) dut_c (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata_c), .pin_in(pin_in[3:0]), .pin_out(out_c), .pin_oe(oe_c), .irq(irq_c));

  // behavioural reference for dut
  bit [7:0]  m_s1, m_s2, m_prev, m_out, m_dir, m_mask, m_cap;
  bit [31:0] m_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    bit [7:0]  det, ncap;
    bit [31:0] rv;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_dir = 0; m_mask = 0; m_cap = 0; m_rd = 0;
    end else begin
      det = m_s2 & ~m_prev;
      rv  = 0;
      if (rd) begin
        case (addr)
          2'd0: rv = {24'd0, m_s2};
          2'd1: rv = {24'd0, m_dir};
          2'd2: rv = {24'd0, m_mask};
          default: rv = {24'd0, m_cap};
        endcase
      end
      ncap = ((wr && addr == 2'd3) ? 8'd0 : m_cap) | det;
      if (wr && addr == 2'd0) m_out  = wdata[7:0];
      if (wr && addr == 2'd1) m_dir  = wdata[7:0];
      if (wr && addr == 2'd2) m_mask = wdata[7:0];
      m_cap = ncap; m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_rd = rv;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R2 model rdata", rdata_a, m_rd);
    chk("R3 model pin_out", {24'd0, out_a}, {24'd0, m_out});
    chk("R4 model pin_oe", {24'd0, oe_a}, {24'd0, m_dir});
    chk("R8 model irq", {31'd0, irq_a}, {31'd0, |(m_cap & m_mask)});
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    addr = a; rd = 1'b1;
    step();
    rd = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 pin_out", {24'd0, out_a}, 32'h0);
    chk("R1 pin_oe bidir", {24'd0, oe_a}, 32'h0);
    chk("R1 irq edge", {31'd0, irq_a}, 32'h0);
    chk("R1 irq level", {31'd0, irq_b}, 32'h0);
    chk("R1 rdata", rdata_a, 32'h0);

    bus_write(2'd2, 32'h0000_00FF);
    bus_write(2'd1, 32'hFFFF_FF0F);
    chk("R4 dir drives pin_oe", {24'd0, oe_a}, 32'h0F);
    chk("R4 in/out oe all ones", {24'd0, oe_b}, 32'hFF);
    chk("R4 out-only oe all ones", {28'd0, oe_c}, 32'hF);
    bus_write(2'd0, 32'hABCD_123C);
    chk("R3 pin_out bidir", {24'd0, out_a}, 32'h3C);
    chk("R3 pin_out in/out", {24'd0, out_b}, 32'h3C);
    chk("R3 pin_out out-only", {28'd0, out_c}, 32'hC);

    // rising edges on bits 7 and 0
    pin_in = 8'h81;
    repeat (3) step();
    chk("R8 edge irq set", {31'd0, irq_a}, 32'h1);
    chk("R9 level irq set", {31'd0, irq_b}, 32'h1);
    bus_read(2'd3);
    chk("R6 rising capture", rdata_a, 32'h81);
    chk("R6 either capture", rdata_b, 32'h81);

    bus_write(2'd3, 32'h0);
    chk("R8 irq after clear", {31'd0, irq_a}, 32'h0);
    bus_read(2'd3);
    chk("R7 clear rising", rdata_a, 32'h0);
    chk("R7 clear either", rdata_b, 32'h0);

    // bit 0 falls
    pin_in = 8'h80;
    repeat (3) step();
    bus_read(2'd3);
    chk("R6 falling ignored by rising", rdata_a, 32'h0);
    chk("R6 falling caught by either", rdata_b, 32'h01);
    chk("R9 level irq bit7", {31'd0, irq_b}, 32'h1);

    bus_write(2'd2, 32'h02);
    chk("R9 masked level low", {31'd0, irq_b}, 32'h0);
    pin_in = 8'h82;
    repeat (3) step();
    chk("R9 unmasked level high", {31'd0, irq_b}, 32'h1);
    chk("R8 unmasked edge high", {31'd0, irq_a}, 32'h1);

    // edge detected in the same cycle as the clear
    pin_in = 8'h92;
    step();
    step();
    bus_write(2'd3, 32'h5);
    chk("R8 masked edge low", {31'd0, irq_a}, 32'h0);
    bus_read(2'd3);
    chk("R7 collision rising", rdata_a, 32'h10);
    chk("R7 collision either", rdata_b, 32'h10);

    bus_read(2'd0);
    chk("R5 data read bidir", rdata_a, 32'h92);
    chk("R5 data read in/out", rdata_b, 32'h92);
    chk("R10 out-only data read", rdata_c, 32'h0);
    step();
    chk("R2 idle rdata zero", rdata_a, 32'h0);

    // one edge of settling is not enough
    pin_in = 8'h5A;
    step();
    bus_read(2'd0);
    chk("R5 sync latency old value", rdata_a, 32'h92);
    bus_read(2'd0);
    chk("R5 sync new value", rdata_a, 32'h5A);

    bus_read(2'd1);
    chk("R4 dir readback", rdata_a, 32'h0F);
    chk("R10 dir absent in/out", rdata_b, 32'h0);
    bus_read(2'd2);
    chk("R10 out-only mask read", rdata_c, 32'h0);
    chk("R10 out-only irq", {31'd0, irq_c}, 32'h0);

    repeat (4) step();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule